// File: doc/BRIEF.md
# Command-Indexed Host Register Port

This block is the processor-facing side of a peripheral. A microprocessor reaches a set of internal registers through a 16-bit data bus, one address line and three active-low controls: chip select, read strobe and write strobe. Every access starts with a command phase. The processor writes a command word with the address line high, and that word picks the target and the direction. One or more data phases then follow with the address line low, and these move the data.

Three kinds of target sit behind the command. The first is a set of 16-bit registers, each completed by one data phase. The second is a set of 32-bit registers, each taking two ordered data phases: the lower half moves first, then the upper half. The third is a small word buffer that takes as many data phases as the processor issues, through a pointer that advances by itself. A write to a 32-bit register is staged and committed in one step. A read from a 32-bit register takes both halves at the same moment.

The block samples the bus controls on the system clock. It acts once on each falling edge of a strobe, and it drives read data only while a read is in progress.

Top module: `hreg_port`

## Requirements
- R1: After reset every register reads zero, no command is active and `dq_oe` is low.
- R2: A falling write strobe with `cs_n` low and `a0` high is a command. Bits 6:0 of the word give the target code and bit 7 gives the direction (1 = write, 0 = read). Bits 15:8 have no effect.
- R3: Codes 0x00 to 0x03 are 16-bit registers. After a write command, one falling write strobe with `a0` low stores `dq_in` in the register.
- R4: After a read command to a 16-bit register, the first read phase returns the register and ends the access. Any further data phase is ignored on write and returns zero on read.
- R5: Codes 0x10 to 0x13 are 32-bit registers. The first data phase moves bits 15:0 and the second moves bits 31:16.
- R6: A 32-bit register keeps its old value until the upper half is written. The lower half alone changes nothing that can be read back.
- R7: A data phase whose direction disagrees with the command flag is ignored on write and returns zero on read. It does not count as a phase.
- R8: A data phase with no active command, or after a command to an unassigned code, is ignored on write and returns zero on read.
- R9: A new command abandons any access that is not finished.
- R10: Code 0x20 is the word buffer. Each buffer command resets the word pointer to 0, and each data phase accesses the word at the pointer and then advances the pointer by one.
- R11: The buffer pointer wraps from the last word (64 words by default) back to word 0.
- R12: `dq_oe` is high only while `cs_n` and `rd_n` are both low, and `dq_out` is zero otherwise. A strobe held low is acted on only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | 1 = command phase, 0 = data phase |
| dq_in | input | 16 | Write data or command word from the processor |
| dq_out | output | 16 | Read data to the processor |
| dq_oe | output | 1 | High while the port drives read data |

## Verification
The case where two functions collide is a new command arriving while a 32-bit write has its lower half staged and waits for the upper half. The abort path and the commit path both act on that same pending state. The bench provokes this by writing only the lower half and then issuing a read command to the same register. It judges the result by checking that both halves read back with their earlier value. A second collision is a buffer command that arrives after the pointer has wrapped. The pointer must restart at word 0, and the bench confirms this from the words it reads back, which show where the wrapped writes landed.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  typedef enum logic [1:0] {CLS_NONE, CLS_R16, CLS_R32, CLS_BUF} cls_e;

  // Map a 7-bit target code onto the kind of storage behind it.
  function automatic cls_e classify(input logic [6:0] code, input int n16,
                                    input int base32, input int n32, input int bufcode);
    int v;
    v = int'(code);
    if (v < n16) return CLS_R16;
    if (v >= base32 && v < base32 + n32) return CLS_R32;
    if (v == bufcode) return CLS_BUF;
    return CLS_NONE;
  endfunction

  // Word pointer step with wrap at the end of the buffer.
  function automatic logic [15:0] ptr_next(input logic [15:0] p, input int depth);
    return (int'(p) >= depth - 1) ? 16'd0 : p + 16'd1;
  endfunction
endpackage

// File: rtl/hrp_strobe.sv
module hrp_strobe (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        a0,
  input  logic [15:0] dq_in,
  output logic [15:0] s_din,
  output logic        ev_cmd,
  output logic        ev_wdat,
  output logic        ev_rdat
);
  logic s_cs, s_rd, s_wr, s_a0, p_rd, p_wr;
  logic wr_fall, rd_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cs <= 1'b1; s_rd <= 1'b1; s_wr <= 1'b1; s_a0 <= 1'b0;
      p_rd <= 1'b1; p_wr <= 1'b1; s_din <= '0;
    end else begin
      s_cs <= cs_n; s_rd <= rd_n; s_wr <= wr_n; s_a0 <= a0; s_din <= dq_in;
      p_rd <= s_rd; p_wr <= s_wr;
    end
  end

  assign wr_fall = p_wr & ~s_wr & ~s_cs;
  assign rd_fall = p_rd & ~s_rd & ~s_cs;
  assign ev_cmd  = wr_fall & s_a0;
  assign ev_wdat = wr_fall & ~s_a0;
  assign ev_rdat = rd_fall & ~s_a0;

  a_r12_write_edge_once: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall |=> !wr_fall);
  a_r12_read_edge_once: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fall |=> !rd_fall);
endmodule

// File: rtl/hrp_seq.sv
module hrp_seq
  import hrp_pkg::*;
#(
  parameter int N16     = 4,
  parameter int BASE32  = 16,
  parameter int N32     = 4,
  parameter int BUFCODE = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_cmd,
  input  logic       ev_wdat,
  input  logic       ev_rdat,
  input  logic [7:0] cmd_byte,
  output logic       acc_wr,
  output logic       acc_rd,
  output cls_e       acc_cls,
  output logic [6:0] acc_idx,
  output logic       acc_hi,
  output logic       buf_restart
);
  logic vld, dir;
  cls_e new_cls;

  assign new_cls     = classify(cmd_byte[6:0], N16, BASE32, N32, BUFCODE);
  assign buf_restart = ev_cmd & (new_cls == CLS_BUF);
  assign acc_wr      = ev_wdat & vld & dir;
  assign acc_rd      = ev_rdat & vld & ~dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0; dir <= 1'b0; acc_hi <= 1'b0; acc_cls <= CLS_NONE; acc_idx <= '0;
    end else if (ev_cmd) begin
      vld     <= (new_cls != CLS_NONE);
      dir     <= cmd_byte[7];
      acc_idx <= cmd_byte[6:0];
      acc_cls <= new_cls;
      acc_hi  <= 1'b0;
    end else if (acc_wr | acc_rd) begin
      case (acc_cls)
        CLS_R16: vld <= 1'b0;
        CLS_R32: if (acc_hi) vld <= 1'b0; else acc_hi <= 1'b1;
        default: ;
      endcase
    end
  end

  a_r4_single_phase_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr | acc_rd) && acc_cls == CLS_R16 |=> !vld);
  a_r5_upper_follows_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr | acc_rd) && acc_cls == CLS_R32 && !acc_hi |=> vld && acc_hi);
  a_r9_command_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd |=> !acc_hi);
endmodule

// File: rtl/hrp_regs.sv
module hrp_regs
  import hrp_pkg::*;
#(
  parameter int N16    = 4,
  parameter int BASE32 = 16,
  parameter int N32    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_wr,
  input  logic        acc_rd,
  input  cls_e        acc_cls,
  input  logic [6:0]  acc_idx,
  input  logic        acc_hi,
  input  logic [15:0] din,
  output logic [15:0] rdata
);
  localparam int W16 = (N16 > 1) ? $clog2(N16) : 1;
  localparam int W32 = (N32 > 1) ? $clog2(N32) : 1;

  logic [N16-1:0][15:0] r16_q;
  logic [N32-1:0][31:0] r32_q;
  logic [15:0] stage_q, upper_snap;
  logic [W16-1:0] i16;
  logic [W32-1:0] i32;
  logic [6:0] off32;

  assign i16   = acc_idx[W16-1:0];
  assign off32 = acc_idx - 7'(BASE32);
  assign i32   = off32[W32-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r16_q <= '0; r32_q <= '0; stage_q <= '0; upper_snap <= '0;
    end else begin
      if (acc_wr && acc_cls == CLS_R16) r16_q[i16] <= din;
      if (acc_wr && acc_cls == CLS_R32) begin
        if (!acc_hi) stage_q <= din;
        else         r32_q[i32] <= {din, stage_q};
      end
      if (acc_rd && acc_cls == CLS_R32 && !acc_hi) upper_snap <= r32_q[i32][31:16];
    end
  end

  always_comb begin
    case (acc_cls)
      CLS_R16: rdata = r16_q[i16];
      CLS_R32: rdata = acc_hi ? upper_snap : r32_q[i32][15:0];
      default: rdata = '0;
    endcase
  end

  a_r6_lower_only_staged: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && acc_cls == CLS_R32 && !acc_hi |=> $stable(r32_q));
endmodule

// File: rtl/hrp_buf.sv
module hrp_buf
  import hrp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        sel,
  input  logic        acc_wr,
  input  logic        acc_rd,
  input  logic [15:0] din,
  output logic [15:0] rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [15:0] mem [DEPTH];
  logic [15:0] ptr;

  always_ff @(posedge clk) begin
    if (sel && acc_wr) mem[ptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ptr <= '0;
    else if (restart)                  ptr <= '0;
    else if (sel && (acc_wr || acc_rd)) ptr <= ptr_next(ptr, DEPTH);
  end

  assign rdata = mem[ptr[AW-1:0]];

  a_r10_pointer_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ptr == 16'd0);
  a_r11_pointer_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < DEPTH);
endmodule

// File: rtl/hreg_port.sv
module hreg_port
  import hrp_pkg::*;
#(
  parameter int N16       = 4,
  parameter int BASE32    = 16,
  parameter int N32       = 4,
  parameter int BUFCODE   = 32,
  parameter int BUF_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        a0,
  input  logic [15:0] dq_in,
  output logic [15:0] dq_out,
  output logic        dq_oe
);
  logic [15:0] s_din, reg_rdata, buf_rdata, rd_hold;
  logic ev_cmd, ev_wdat, ev_rdat, acc_wr, acc_rd, acc_hi, buf_restart;
  logic [6:0] acc_idx;
  cls_e acc_cls;

  hrp_strobe u_strobe (
    .clk, .rst_n, .cs_n, .rd_n, .wr_n, .a0, .dq_in,
    .s_din, .ev_cmd, .ev_wdat, .ev_rdat
  );

  hrp_seq #(.N16(N16), .BASE32(BASE32), .N32(N32), .BUFCODE(BUFCODE)) u_seq (
    .clk, .rst_n, .ev_cmd, .ev_wdat, .ev_rdat, .cmd_byte(s_din[7:0]),
    .acc_wr, .acc_rd, .acc_cls, .acc_idx, .acc_hi, .buf_restart
  );

  hrp_regs #(.N16(N16), .BASE32(BASE32), .N32(N32)) u_regs (
    .clk, .rst_n, .acc_wr, .acc_rd, .acc_cls, .acc_idx, .acc_hi,
    .din(s_din), .rdata(reg_rdata)
  );

  hrp_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk, .rst_n, .restart(buf_restart), .sel(acc_cls == CLS_BUF),
    .acc_wr, .acc_rd, .din(s_din), .rdata(buf_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_hold <= '0;
    else if (ev_rdat) rd_hold <= !acc_rd ? 16'd0 :
                                 (acc_cls == CLS_BUF) ? buf_rdata : reg_rdata;
  end

  assign dq_oe  = ~cs_n & ~rd_n;
  assign dq_out = dq_oe ? rd_hold : 16'd0;

  a_r12_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> dq_out == 16'd0);
endmodule

// File: tb/hreg_port_tb.sv
module hreg_port_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic dq_oe;

  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  event samp;

  always #(CLK_PERIOD/2) clk = ~clk;

  hreg_port u_dut (.clk, .rst_n, .cs_n, .rd_n, .wr_n, .a0, .dq_in, .dq_out, .dq_oe);

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wstrobe(input logic addr, input logic [15:0] d);
    cs_n = 1'b0; a0 = addr; dq_in = d; wr_n = 1'b0;
    cyc(3);
    wr_n = 1'b1; cs_n = 1'b1;
    cyc(2);
  endtask

  task automatic cmd(input logic [15:0] c);  wstrobe(1'b1, c); endtask
  task automatic put(input logic [15:0] d);  wstrobe(1'b0, d); endtask

  task automatic get(input logic [15:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    cs_n = 1'b0; a0 = 1'b0; rd_n = 1'b0;
    cyc(3);
    -> samp;
    #1;
    rd_n = 1'b1; cs_n = 1'b1;
    cyc(2);
  endtask

  // Monitor: pops the expected item and compares with the bus.
  initial begin
    forever begin
      @(samp);
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard underflow actual=%h expected=none", dq_out);
      end else begin
        string t;
        logic [15:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({15'd0, dq_oe}, 16'd1, {t, " oe"});
        check(dq_out, e, t);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    check({15'd0, dq_oe}, 16'd0, "R1 oe after reset");
    rst_n = 1'b1;
    cyc(2);
    cmd(16'h0000); get(16'h0000, "R1 reg16 reset");
    cmd(16'h0011); get(16'h0000, "R1 reg32 reset lo"); get(16'h0000, "R1 reg32 reset hi");

    // R2 / R3: upper command byte ignored
    cmd(16'hAB82); put(16'h1234);
    cmd(16'h0002); get(16'h1234, "R3 reg16 write/read");
    get(16'h0000, "R4 extra read phase");
    cmd(16'h0083); put(16'hC0DE); put(16'h9999);
    cmd(16'h0003); get(16'hC0DE, "R4 extra write ignored");

    // R7: direction mismatch not counted
    cmd(16'h0002); put(16'h5555); get(16'h1234, "R7 wrong-direction write");
    cmd(16'h0083); get(16'h0000, "R7 wrong-direction read");
    put(16'h7777);
    cmd(16'h0003); get(16'h7777, "R7 write after mismatch");

    // R5: 32-bit ordering
    cmd(16'h0091); put(16'hBEEF); put(16'hDEAD);
    cmd(16'h0011); get(16'hBEEF, "R5 lower half"); get(16'hDEAD, "R5 upper half");

    // R6 / R9: lower half then new command aborts
    cmd(16'h0091); put(16'h1111);
    cmd(16'h0011); get(16'hBEEF, "R6 R9 abort lo"); get(16'hDEAD, "R6 R9 abort hi");
    get(16'h0000, "R4 third phase on reg32");

    // R8: no command / unassigned code
    cmd(16'h00D0); put(16'h4242);
    cmd(16'h0050); get(16'h0000, "R8 unassigned code");
    cmd(16'h0002); get(16'h1234, "R8 other regs untouched");
    put(16'h3333); get(16'h0000, "R8 no active command");

    // R10: buffer streaming
    cmd(16'h00A0); put(16'hA001); put(16'hA002); put(16'hA003);
    cmd(16'h0020); get(16'hA001, "R10 buf word0"); get(16'hA002, "R10 buf word1");
    get(16'hA003, "R10 buf word2");

    // R11: wrap past the last word
    cmd(16'h00A0);
    for (int i = 0; i < 66; i++) put(16'h0100 + 16'(i));
    cmd(16'h0020); get(16'h0140, "R11 wrap word0"); get(16'h0141, "R11 wrap word1");
    get(16'h0102, "R11 word2 kept");

    // R12: no drive without chip select
    rd_n = 1'b0; cs_n = 1'b1; a0 = 1'b0;
    cyc(4);
    check({15'd0, dq_oe}, 16'd0, "R12 oe without cs");
    check(dq_out, 16'h0000, "R12 data without cs");
    rd_n = 1'b1;
    cyc(2);
    get(16'h0103, "R12 cs-less read did not advance pointer");

    cyc(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule